// File: doc/BRIEF.md
# Write-Once System Options Register

This block holds an 8-bit configuration byte that sets up a small controller's system behaviour. Software reaches it over a simple CPU-style bus: an address-match select, a write strobe, write data and read data. After each reset the block accepts one write only. It locks after that first write and discards every later write until the next reset. Software can read the byte at any time.

The stored fields drive five functions:
- a watchdog enable;
- a watchdog long/short timeout choice;
- a permit for low-power stop mode;
- a function select for a shared debug pin;
- a function select for a shared reset pin, which also turns on that pin's pull-up.

Most fields return to fixed values on every reset. The reset-pin select is different: it is cleared only by power-on or low-voltage resets, and it keeps its value through any other reset. The reset source is supplied as an input code.

The block also watches a strobe that reports an executed stop instruction. If stop mode is permitted, it pulses an acknowledge. If stop mode is not permitted, it pulses an illegal-operation reset request.

Top module: `sysopt_wo_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register loads bit 7 = 1, bit 6 = 1, bit 5 = 0, bit 4 = 1 and bit 1 = 1, so `bus_rdata` reads 8'hD2 or 8'hD3 after reset.
- R2: Bit 0 is cleared by a reset when `rst_src` is 2'b01 (power-on) or 2'b10 (low-voltage). It keeps its previous value when `rst_src` is 2'b00 or 2'b11.
- R3: The first cycle after reset with `bus_sel` and `bus_wr` both high stores `bus_wdata` at that clock edge, and the new value is visible from the next cycle.
- R4: After that first write, every further write is ignored until the next reset, and the write after that reset is accepted again.
- R5: A cycle with `bus_sel` or `bus_wr` low changes nothing and does not lock the register.
- R6: `bus_rdata` shows the stored byte at all times. Reading does not consume the single allowed write.
- R7: Bits 3 and 2 always read 0, whatever value is written to them.
- R8: Bit 4 stores written data and reads it back, but drives no output.
- R9: The outputs map to the stored bits as follows: `wdog_en` = bit 7, `wdog_long` = bit 6, `stop_permit` = bit 5, `dbg_pin_en` = bit 1. Both `rstpin_en` and `rstpin_pullup` equal bit 0.
- R10: When `stop_exec` is high at an edge while bit 5 is 0, `illop_rst_req` is high for the following cycle and `stop_ack` stays low.
- R11: When `stop_exec` is high at an edge while bit 5 is 1, `stop_ack` is high for the following cycle and `illop_rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_src | input | 2 | Reset cause: 00 other, 01 power-on, 10 low-voltage, 11 other |
| bus_sel | input | 1 | Address decode hit for this register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, bits 3:2 forced to 0 |
| stop_exec | input | 1 | Stop instruction executed strobe |
| wdog_en | output | 1 | Watchdog enable |
| wdog_long | output | 1 | Watchdog long timeout select |
| stop_permit | output | 1 | Stop mode permitted |
| dbg_pin_en | output | 1 | Shared pin in debug function |
| rstpin_en | output | 1 | Shared pin in reset-input function |
| rstpin_pullup | output | 1 | Pull-up enable for the reset pin |
| illop_rst_req | output | 1 | One-cycle illegal-operation reset request |
| stop_ack | output | 1 | One-cycle stop-entry acknowledge |

## Verification
Every result in this block is due exactly one clock edge after its cause:
- a reset image appears after the edge that samples `rst`;
- a written byte appears after the edge that samples the write;
- a stop response pulses in the cycle after the edge that samples `stop_exec`, and clears one cycle later.

The bench drives inputs on falling edges. Each expectation is queued with the cycle count at which it falls due. A monitor compares it shortly after the falling edge of that same cycle, so every sample lands one register stage after its stimulus and never at an edge.

// File: rtl/sysopt_pkg.sv
package sysopt_pkg;

    localparam int REG_W         = 8;
    localparam int SRC_W         = 2;

    // Bit positions that software and neighbouring blocks decode.
    localparam int POS_WDOG_EN   = 7;
    localparam int POS_WDOG_LONG = 6;
    localparam int POS_STOP_OK   = 5;
    localparam int POS_SPARE     = 4;
    localparam int POS_DBG_PIN   = 1;
    localparam int POS_RST_PIN   = 0;

    typedef enum logic [SRC_W-1:0] {
        SRC_OTHER     = 2'b00,
        SRC_POWER_ON  = 2'b01,
        SRC_LOW_VOLT  = 2'b10,
        SRC_OTHER_ALT = 2'b11
    } rst_src_e;

    // Packed layout matches the bus bit order (MSB first).
    typedef struct packed {
        logic       wdog_en;
        logic       wdog_long;
        logic       stop_ok;
        logic       spare;
        logic [1:0] empty;
        logic       dbg_pin;
        logic       rst_pin;
    } opt_reg_t;

    function automatic logic src_clears_pin(rst_src_e src);
        return (src == SRC_POWER_ON) || (src == SRC_LOW_VOLT);
    endfunction

    function automatic opt_reg_t reset_image(opt_reg_t prev, rst_src_e src);
        opt_reg_t r;
        r.wdog_en   = 1'b1;
        r.wdog_long = 1'b1;
        r.stop_ok   = 1'b0;
        r.spare     = 1'b1;
        r.empty     = 2'b00;
        r.dbg_pin   = 1'b1;
        r.rst_pin   = src_clears_pin(src) ? 1'b0 : prev.rst_pin;
        return r;
    endfunction

    function automatic opt_reg_t take_write(logic [REG_W-1:0] d);
        opt_reg_t r;
        r.wdog_en   = d[POS_WDOG_EN];
        r.wdog_long = d[POS_WDOG_LONG];
        r.stop_ok   = d[POS_STOP_OK];
        r.spare     = d[POS_SPARE];
        r.empty     = 2'b00;
        r.dbg_pin   = d[POS_DBG_PIN];
        r.rst_pin   = d[POS_RST_PIN];
        return r;
    endfunction

endpackage

// File: rtl/sysopt_lock.sv
module sysopt_lock (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    output logic locked
);

    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (wr_hit)
            locked <= 1'b1;
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (locked && !rst) |=> locked); // R4

    AST_HIT_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !rst) |=> locked); // R3

endmodule

// File: rtl/sysopt_store.sv
module sysopt_store
    import sysopt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  rst_src_e         src,
    input  logic             wr_en,
    input  logic             locked,
    input  logic [REG_W-1:0] wdata,
    output opt_reg_t         q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= reset_image(q, src);
        else if (wr_en)
            q <= take_write(wdata);
    end

    AST_NO_WRITE_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        (locked && !rst) |=> $stable(q)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !rst) |=> $stable(q)); // R5

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q.empty == 2'b00)); // R7

endmodule

// File: rtl/sysopt_stop_ctl.sv
module sysopt_stop_ctl (
    input  logic clk,
    input  logic rst,
    input  logic stop_exec,
    input  logic stop_ok,
    output logic illop_req,
    output logic stop_ack
);

    always_ff @(posedge clk) begin
        if (rst) begin
            illop_req <= 1'b0;
            stop_ack  <= 1'b0;
        end else begin
            illop_req <= stop_exec & ~stop_ok;
            stop_ack  <= stop_exec &  stop_ok;
        end
    end

    AST_STOP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({illop_req, stop_ack})); // R10

    AST_DENY_REQUESTS_RESET: assert property (@(posedge clk) disable iff (rst)
        (stop_exec && !stop_ok) |=> (illop_req && !stop_ack)); // R10

    AST_PERMIT_ACKS: assert property (@(posedge clk) disable iff (rst)
        (stop_exec && stop_ok) |=> (stop_ack && !illop_req)); // R11

    AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !stop_exec |=> (!stop_ack && !illop_req)); // R11

endmodule

// File: rtl/sysopt_wo_reg.sv
module sysopt_wo_reg
    import sysopt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] rst_src,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             stop_exec,
    output logic             wdog_en,
    output logic             wdog_long,
    output logic             stop_permit,
    output logic             dbg_pin_en,
    output logic             rstpin_en,
    output logic             rstpin_pullup,
    output logic             illop_rst_req,
    output logic             stop_ack
);

    logic     wr_hit;
    logic     wr_en;
    logic     locked;
    opt_reg_t opt_q;
    rst_src_e src;

    assign src    = rst_src_e'(rst_src);
    assign wr_hit = bus_sel & bus_wr;
    assign wr_en  = wr_hit & ~locked;

    sysopt_lock u_lock (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .locked (locked)
    );

    sysopt_store u_store (
        .clk    (clk),
        .rst    (rst),
        .src    (src),
        .wr_en  (wr_en),
        .locked (locked),
        .wdata  (bus_wdata),
        .q      (opt_q)
    );

    sysopt_stop_ctl u_stop (
        .clk       (clk),
        .rst       (rst),
        .stop_exec (stop_exec),
        .stop_ok   (opt_q.stop_ok),
        .illop_req (illop_rst_req),
        .stop_ack  (stop_ack)
    );

    always_comb begin
        bus_rdata       = opt_q;
        bus_rdata[3:2]  = 2'b00;
    end

    assign wdog_en       = opt_q.wdog_en;
    assign wdog_long     = opt_q.wdog_long;
    assign stop_permit   = opt_q.stop_ok;
    assign dbg_pin_en    = opt_q.dbg_pin;
    assign rstpin_en     = opt_q.rst_pin;
    assign rstpin_pullup = opt_q.rst_pin;

    AST_PULLUP_WITH_PIN: assert property (@(posedge clk) disable iff (rst)
        rstpin_pullup == rstpin_en); // R9

endmodule

// File: tb/sysopt_wo_reg_tb.sv
module sysopt_wo_reg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rst_src = 2'b01;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_exec = 1'b0;
    logic       wdog_en, wdog_long, stop_permit, dbg_pin_en;
    logic       rstpin_en, rstpin_pullup, illop_rst_req, stop_ack;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         due;
        int         sel;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sysopt_wo_reg dut_i (
        .clk(clk), .rst(rst), .rst_src(rst_src),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .stop_exec(stop_exec),
        .wdog_en(wdog_en), .wdog_long(wdog_long), .stop_permit(stop_permit),
        .dbg_pin_en(dbg_pin_en), .rstpin_en(rstpin_en),
        .rstpin_pullup(rstpin_pullup), .illop_rst_req(illop_rst_req),
        .stop_ack(stop_ack)
    );

    // sel 0: read data; sel 1: {wdog_en,wdog_long,stop_permit,dbg,rstpin,pullup,illop,ack}
    function automatic logic [7:0] observe(int sel);
        if (sel == 0) return bus_rdata;
        return {wdog_en, wdog_long, stop_permit, dbg_pin_en,
                rstpin_en, rstpin_pullup, illop_rst_req, stop_ack};
    endfunction

    task automatic push(int sel, logic [7:0] exp, string req);
        item_t it;
        it.due = cyc; it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compare every item that falls due this cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: sel=%0d actual=%h expected=%h at cycle %0d",
                             it.req, it.sel, act, it.exp, cyc);
                end
            end
        end
    end

    task automatic do_reset(logic [1:0] src);
        @(negedge clk);
        rst = 1'b1; rst_src = src;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(logic sel, logic wr, logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_stop(logic [7:0] outs_base, logic [7:0] pulse, string req);
        @(negedge clk);
        stop_exec = 1'b1;
        @(negedge clk);
        stop_exec = 1'b0;
        push(1, outs_base | pulse, req);
        @(negedge clk);
        push(1, outs_base, req);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 R2 R9: power-on reset image
        do_reset(2'b01);
        push(0, 8'hD2, "R1");
        push(1, 8'hD0, "R9");
        // R10: stop while not permitted
        do_stop(8'hD0, 8'h02, "R10");
        // R5 R6: unselected or read-only cycles change nothing
        do_write(1'b0, 1'b1, 8'h00);
        push(0, 8'hD2, "R5");
        do_write(1'b1, 1'b0, 8'h00);
        push(0, 8'hD2, "R6");
        // R3 R7 R9: first write accepted, bits 3:2 dropped
        do_write(1'b1, 1'b1, 8'h2D);
        push(0, 8'h21, "R3");
        push(1, 8'h2C, "R9");
        // R4: later write ignored
        do_write(1'b1, 1'b1, 8'hFF);
        push(0, 8'h21, "R4");
        // R11: stop while permitted
        do_stop(8'h2C, 8'h01, "R11");
        // R2: other reset keeps bit 0
        do_reset(2'b00);
        push(0, 8'hD3, "R2");
        push(1, 8'hDC, "R9");
        // R2: low-voltage reset clears bit 0
        do_reset(2'b10);
        push(0, 8'hD2, "R2");
        // R4 R8: write after reset accepted again; spare bit drives nothing
        do_write(1'b1, 1'b1, 8'h10);
        push(0, 8'h10, "R8");
        push(1, 8'h00, "R8");
        do_write(1'b1, 1'b1, 8'h33);
        push(0, 8'h10, "R4");
        // R2: code 11 behaves as other reset
        do_reset(2'b00);
        do_write(1'b1, 1'b1, 8'h0D);
        push(0, 8'h01, "R7");
        do_reset(2'b11);
        push(0, 8'hD3, "R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule